// File: doc/BRIEF.md
# Packed Raw Pixel Unpacker

This block turns a byte-wide stream of camera line payload into a stream of pixel words. A run-time mode input selects how bytes are grouped into pixels. Plain 8-bit raw data passes one byte per pixel. Packed 10-bit raw data yields four pixels from every five bytes. Packed 12-bit raw data yields two pixels from every three bytes. A little-endian 16-bit format yields one pixel from every two bytes. Unpacked pixels leave the block right-aligned and zero-extended in a 16-bit word. A flag tells whether the word uses the narrow 8-bit packing or the 16-bit container.

Both the input and the output are valid/ready streams. The input byte that opens a line carries a start-of-line marker. This marker restarts the byte-group phase, so bytes left over from an unfinished group at the end of the previous line are dropped. An enable input freezes the whole block: while it is low, no byte is accepted, no pixel is offered, and all internal state is kept.

Top module: `raw_unpacker`

## Requirements
- R1: After a synchronous active-low reset with enable high, out_valid is 0 and in_ready is 1.
- R2: With mode 0, each input byte b gives one pixel equal to {8'h00, b}, and out_wide is 0.
- R3: With mode 1, five bytes b0..b4 give four pixels in order. Pixel k (k = 0..3) equals {6'b0, bk, b4[2k+1:2k]}, and out_wide is 1.
- R4: With mode 2, three bytes b0..b2 give two pixels. The first is {4'b0, b0, b2[3:0]} and the second is {4'b0, b1, b2[7:4]}, and out_wide is 1.
- R5: With mode 3, two bytes b0,b1 give one pixel equal to {b1, b0}, and out_wide is 1.
- R6: Mode values 4 to 7 behave exactly as mode 0.
- R7: A byte accepted with in_sol high is the first byte of a new group. Any partial group already collected is discarded and produces no pixel.
- R8: While enable is low, in_ready and out_valid are 0 and no state changes. After enable returns high, pending pixels come out unchanged and in order.
- R9: Pixels leave in input order with none lost or added. While out_valid is high and out_ready is low, out_pixel and out_wide hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low freezes all activity |
| mode | input | 3 | Format select: 0 raw8, 1 packed10, 2 packed12, 3 le16, others raw8 |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input payload byte |
| in_sol | input | 1 | Marks the first byte of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 16 | Right-aligned, zero-extended pixel |
| out_wide | output | 1 | 1 for 16-bit packing, 0 for 8-bit packing |

## Verification
Lines in every mode are sent with byte values that vary position by position. A wrong byte-to-pixel mapping, or swapped low-bit fields inside the shared packed byte, therefore shows up as a mismatch rather than cancelling out. Several lines end on a partial group before the next marked line, which separates proper discard of leftover bytes from carry-over into the next line. Runs with a toggling and a stalled consumer, and with enable dropped while pixels are pending, tell real flow control apart from designs that only work at full rate.

// File: rtl/raw_pkg.sv
`timescale 1ns/1ps
// Shared widths, the format type and per-format group geometry for the raw unpacker.
package raw_pkg;
    localparam int BYTE_W  = 8;
    localparam int PIX_W   = 16;
    localparam int MODE_W  = 3;
    localparam int MAX_GRP = 5;                       // bytes in the largest group
    localparam int MAX_PIX = 4;                       // pixels in the largest group
    localparam int CNT_W   = $clog2(MAX_GRP + 1);
    localparam int IDX_W   = $clog2(MAX_PIX);

    typedef enum logic [1:0] {
        FMT_RAW8  = 2'd0,
        FMT_RAW10 = 2'd1,
        FMT_RAW12 = 2'd2,
        FMT_LE16  = 2'd3
    } fmt_e;

    // Map the mode input to a format; unknown codes fall back to raw8.
    function automatic fmt_e fmt_decode(input logic [MODE_W-1:0] m);
        case (m)
            3'd1:    return FMT_RAW10;
            3'd2:    return FMT_RAW12;
            3'd3:    return FMT_LE16;
            default: return FMT_RAW8;
        endcase
    endfunction

    // Number of bytes forming one group in a format.
    function automatic logic [CNT_W-1:0] grp_len(input fmt_e f);
        case (f)
            FMT_RAW10: return CNT_W'(5);
            FMT_RAW12: return CNT_W'(3);
            FMT_LE16:  return CNT_W'(2);
            default:   return CNT_W'(1);
        endcase
    endfunction

    // Index of the last pixel a group yields.
    function automatic logic [IDX_W-1:0] grp_last(input fmt_e f);
        case (f)
            FMT_RAW10: return IDX_W'(3);
            FMT_RAW12: return IDX_W'(1);
            default:   return IDX_W'(0);
        endcase
    endfunction
endpackage

// File: rtl/raw_group_collect.sv
`timescale 1ns/1ps
// Gathers input bytes into one complete group for the selected format.
// Assumes mode is steady while a group is being collected; the format is
// captured with the group when its last byte arrives. A start-of-line byte
// always lands in slot 0, dropping any unfinished group.
module raw_group_collect
    import raw_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [MODE_W-1:0]              mode_i,
    input  logic                           in_valid,
    input  logic [BYTE_W-1:0]              in_data,
    input  logic                           in_sol,
    output logic                           in_ready,
    input  logic                           take,
    output logic                           grp_full,
    output fmt_e                           grp_fmt,
    output logic [MAX_GRP-1:0][BYTE_W-1:0] grp_bytes
);
    logic [BYTE_W-1:0] byte_q [MAX_GRP];
    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    fmt_e              fmt_q;
    fmt_e              fmt_now;
    logic [CNT_W-1:0]  len_now;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  nxt;
    logic              acc;

    // Decode the format and the slot the next byte goes to.
    always_comb begin
        fmt_now  = fmt_decode(mode_i);
        len_now  = grp_len(fmt_now);
        in_ready = enable && (!full_q || take);
        acc      = in_valid && in_ready;
        base     = in_sol ? '0 : cnt_q;
        nxt      = base + CNT_W'(1);
    end

    // Track the fill count, the full flag and the captured format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            fmt_q  <= FMT_RAW8;
        end else begin
            if (take) full_q <= 1'b0;
            if (acc) begin
                if (nxt == len_now) begin
                    full_q <= 1'b1;
                    cnt_q  <= '0;
                    fmt_q  <= fmt_now;
                end else begin
                    cnt_q <= nxt;
                end
            end
        end
    end

    for (genvar gi = 0; gi < MAX_GRP; gi++) begin : g_lane
        // Store the accepted byte into its slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q[gi] <= '0;
            else if (acc && base == CNT_W'(gi))
                byte_q[gi] <= in_data;
        end
        assign grp_bytes[gi] = byte_q[gi];
    end

    assign grp_full = full_q;
    assign grp_fmt  = fmt_q;

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(cnt_q) && $stable(full_q))); // R8

    AST_SOL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sol && len_now > CNT_W'(1)) |=> (cnt_q == CNT_W'(1))); // R7
endmodule

// File: rtl/raw_pixel_extract.sv
`timescale 1ns/1ps
// Pure combinational pick of one pixel from a stored group.
// Assumes idx never exceeds the last pixel index of the format.
module raw_pixel_extract
    import raw_pkg::*;
(
    input  fmt_e                           fmt,
    input  logic [MAX_GRP-1:0][BYTE_W-1:0] bytes,
    input  logic [IDX_W-1:0]               idx,
    output logic [PIX_W-1:0]               pixel,
    output logic                           wide
);
    // Select the high part and low bits of the requested pixel.
    always_comb begin
        wide = 1'b1;
        case (fmt)
            FMT_RAW10: pixel = {6'b0, bytes[idx], bytes[4][{idx, 1'b0} +: 2]};
            FMT_RAW12: pixel = {4'b0, bytes[idx[0]], bytes[2][{idx[0], 2'b00} +: 4]};
            FMT_LE16:  pixel = {bytes[1], bytes[0]};
            default: begin
                pixel = {8'b0, bytes[0]};
                wide  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/raw_pixel_emit.sv
`timescale 1ns/1ps
// Holds one group and hands out its pixels one per transfer.
// Takes the next group when idle or on the transfer of its last pixel,
// so back-to-back groups leave without a bubble.
module raw_pixel_emit
    import raw_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic                           grp_full,
    input  fmt_e                           grp_fmt,
    input  logic [MAX_GRP-1:0][BYTE_W-1:0] grp_bytes,
    output logic                           take,
    input  logic                           out_ready,
    output logic                           out_valid,
    output logic [PIX_W-1:0]               out_pixel,
    output logic                           out_wide
);
    logic                           busy_q;
    logic [IDX_W-1:0]               idx_q;
    fmt_e                           fmt_q;
    logic [MAX_GRP-1:0][BYTE_W-1:0] bytes_q;
    logic                           fire;
    logic                           last;

    // Handshake and group hand-over decisions.
    always_comb begin
        out_valid = busy_q && enable;
        fire      = out_valid && out_ready;
        last      = (idx_q == grp_last(fmt_q));
        take      = enable && grp_full && (!busy_q || (fire && last));
    end

    // Load a group or step to its next pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            idx_q   <= '0;
            fmt_q   <= FMT_RAW8;
            bytes_q <= '0;
        end else if (take) begin
            busy_q  <= 1'b1;
            idx_q   <= '0;
            fmt_q   <= grp_fmt;
            bytes_q <= grp_bytes;
        end else if (fire) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + IDX_W'(1);
        end
    end

    raw_pixel_extract u_extract (
        .fmt   (fmt_q),
        .bytes (bytes_q),
        .idx   (idx_q),
        .pixel (out_pixel),
        .wide  (out_wide)
    );

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (!enable || (out_valid && $stable(out_pixel) && $stable(out_wide)))); // R9

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= grp_last(fmt_q))); // R3

    AST_NARROW_RAW8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_pixel[PIX_W-1:BYTE_W] == '0)); // R2
endmodule

// File: rtl/raw_unpacker.sv
`timescale 1ns/1ps
// Top of the packed raw pixel unpacker: byte stream in, pixel stream out.
// Assumes mode changes only between lines.
module raw_unpacker
    import raw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [MODE_W-1:0] mode,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_wide
);
    logic                           take;
    logic                           grp_full;
    fmt_e                           grp_fmt;
    logic [MAX_GRP-1:0][BYTE_W-1:0] grp_bytes;

    raw_group_collect u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mode_i    (mode),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sol    (in_sol),
        .in_ready  (in_ready),
        .take      (take),
        .grp_full  (grp_full),
        .grp_fmt   (grp_fmt),
        .grp_bytes (grp_bytes)
    );

    raw_pixel_emit u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .grp_full  (grp_full),
        .grp_fmt   (grp_fmt),
        .grp_bytes (grp_bytes),
        .take      (take),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_pixel (out_pixel),
        .out_wide  (out_wide)
    );

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!in_ready && !out_valid)); // R8
endmodule

// File: tb/sim_raw_unpacker.sv
`timescale 1ns/1ps
module sim_raw_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [2:0]  mode = 3'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        in_sol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_pixel;
    logic        out_wide;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;           // 0 always ready, 1 toggling, 2 stalled
    logic [24:0] exp_q [$];     // {req, wide, pixel}

    always #2.5 clk = ~clk;

    raw_unpacker u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sol(in_sol),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel), .out_wide(out_wide)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Monitor: drive consumer ready, then compare each transfer with the scoreboard.
    always @(negedge clk) begin
        cyc++;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 1;
            default: out_ready = 1'b0;
        endcase
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 extra pixel", int'(out_pixel), 0);
            end else begin
                logic [24:0] e;
                e = exp_q.pop_front();
                check({out_wide, out_pixel} == e[16:0], $sformatf("R%0d", e[24:17]),
                      int'({out_wide, out_pixel}), int'(e[16:0]));
            end
        end
    end

    function automatic logic [7:0] gen_byte(input int seed, input int i);
        return 8'((seed * 29 + i * 53 + i * i * 7) & 255);
    endfunction

    // Driver: push expected pixels of all complete groups, then send the line.
    task automatic send_line(input logic [2:0] m, input int n, input int seed, input int req);
        logic [7:0] b [$];
        int glen;
        for (int i = 0; i < n; i++) b.push_back(gen_byte(seed, i));
        glen = (m == 3'd1) ? 5 : (m == 3'd2) ? 3 : (m == 3'd3) ? 2 : 1;
        for (int g = 0; g + glen <= n; g += glen) begin
            case (m)
                3'd1: for (int p = 0; p < 4; p++)
                    exp_q.push_back({8'(req), 1'b1,
                        16'((int'(b[g+p]) << 2) | ((int'(b[g+4]) >> (2*p)) & 3))});
                3'd2: begin
                    exp_q.push_back({8'(req), 1'b1, 16'((int'(b[g]) << 4) | (int'(b[g+2]) & 15))});
                    exp_q.push_back({8'(req), 1'b1, 16'((int'(b[g+1]) << 4) | (int'(b[g+2]) >> 4))});
                end
                3'd3: exp_q.push_back({8'(req), 1'b1, b[g+1], b[g]});
                default: exp_q.push_back({8'(req), 1'b0, 8'h00, b[g]});
            endcase
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mode = m; in_valid = 1'b1; in_data = b[i]; in_sol = (i == 0);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sol = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int w = 0; w < 300 && exp_q.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

        send_line(3'd0, 7, 1, 2);             // R2 raw8
        send_line(3'd1, 13, 2, 3);            // R3 packed10, 3 bytes left over
        send_line(3'd2, 9, 3, 4);             // R4 packed12 after the R7 discard
        send_line(3'd3, 9, 4, 5);             // R5 le16, 1 byte left over
        send_line(3'd1, 10, 11, 7);           // R7 new line drops the le16 leftover
        send_line(3'd5, 4, 5, 6);             // R6 unused code as raw8
        send_line(3'd7, 3, 6, 6);             // R6
        drain("R7 no stray pixels");

        rdy_mode = 1;                          // R9 back-pressure
        send_line(3'd2, 14, 7, 9);
        send_line(3'd1, 20, 8, 9);
        send_line(3'd3, 6, 9, 9);
        drain("R9 all pixels delivered");

        rdy_mode = 2;                          // R8 enable gating
        send_line(3'd1, 5, 10, 8);
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b1, "R8 pending before disable", int'(out_valid), 1);
        @(negedge clk);
        enable = 1'b0;
        in_valid = 1'b1; in_sol = 1'b1; in_data = 8'hA5; mode = 3'd0;
        for (int k = 0; k < 5; k++) begin
            #1;
            check(out_valid == 1'b0, "R8 out_valid while off", int'(out_valid), 0);
            check(in_ready == 1'b0, "R8 in_ready while off", int'(in_ready), 0);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sol = 1'b0;
        enable = 1'b1;
        rdy_mode = 0;
        drain("R8 pixels resume after enable");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule